// File: doc/BRIEF.md
# Segmented Inversion Codec for an Active-Low Data Bus

This block sits next to a wide active-low parallel data bus. It lowers the worst-case number of lines pulled low in any one data phase. On the transmit path, a 64-bit beat is split into four 16-bit segments, and the logical ones in each segment are counted. Every bus line is active-low, so a logical 1 is a line driven low, and the count of ones in a segment is the number of lines it would pull low. A segment with more ones than half its width is sent complemented, and its inversion flag is asserted. The flags are active-low as well.

The receive path takes a bus word and its four flags. It complements every segment whose flag is asserted and restores the original beat. Each path handles one beat per cycle in which its valid input is high. Each path presents its result one clock later on registered outputs, with a matching valid output. Every beat is judged on its own, with no history carried between beats.

The block has no control state beyond one valid register per path. Each path has two conditions: holding (the valid output is low and the registers keep their last contents) and presenting (a beat was accepted on the previous edge). The transition to presenting happens on any edge where the valid input is high. The transition back to holding happens on any edge where it is low.

Top module: `dbi_codec`

## Requirements
- R1: Flag bit k (k = 0..3) of both flag buses governs data bits [16k+15:16k]; a segment's decision never depends on, or changes, another segment.
- R2: On transmit, a segment with 9 or more logical ones is sent bitwise complemented, and its flag bit is driven 0 (asserted, active-low).
- R3: On transmit, a segment with 8 or fewer logical ones, including exactly 8, is sent unchanged, and its flag bit is driven 1.
- R4: No valid transmitted segment ever carries more than 8 logical ones (lines driven low).
- R5: On receive, a segment whose flag bit is 0 is complemented, and a segment whose flag bit is 1 passes unchanged.
- R6: Each beat is encoded from its own data only, so back-to-back beats with different content are each encoded correctly.
- R7: Each path's outputs reflect the beat accepted on the previous rising edge, and its valid output equals its valid input one cycle earlier.
- R8: While a path's valid input is low, its data and flag outputs keep their previous values.
- R9: After reset, both valid outputs are 0, both data outputs are 0, and the transmit flags are all 1.
- R10: Decoding the transmit path's bus word and flags returns the original beat exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | A beat to encode is present on tx_data |
| tx_data | input | 64 | Logical beat to encode |
| txo_valid | output | 1 | Encoded beat present on txo_bus and txo_inv_n |
| txo_bus | output | 64 | Encoded bus word (logical 1 = line driven low) |
| txo_inv_n | output | 4 | Per-segment inversion flags, 0 = segment complemented |
| rx_valid | input | 1 | A bus word to decode is present on rx_bus |
| rx_bus | input | 64 | Received bus word |
| rx_inv_n | input | 4 | Received per-segment inversion flags, 0 = complemented |
| rxo_valid | output | 1 | Decoded beat present on rxo_data |
| rxo_data | output | 64 | Restored logical beat |

## Verification
The assertions assume that each valid input is a clean, synchronous level that is low while reset is asserted. They also assume that the data and flag inputs are known whenever the matching valid is high. The decoder properties accept any flag pattern, so they make no assumption that a received word was produced by a matching encoder. The stimulus drives every input only on falling edges and holds the valids low through reset. It feeds the receive path either with the transmit path's own output or with directed flag patterns, so both the lossless and the arbitrary-flag cases stay inside those assumptions.

// File: rtl/dbi_codec_pkg.sv
package dbi_codec_pkg;

    parameter int SEG_W   = 16;
    parameter int N_SEG   = 4;
    localparam int DATA_W = SEG_W * N_SEG;
    localparam int CNT_W  = $clog2(SEG_W + 1);
    localparam int LOW_LIMIT = SEG_W / 2;

    // number of logical ones (low-driven lines) in one segment
    function automatic logic [CNT_W-1:0] seg_ones(input logic [SEG_W-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < SEG_W; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/dbi_seg_judge.sv
module dbi_seg_judge
    import dbi_codec_pkg::*;
(
    input  logic [SEG_W-1:0] seg_in,
    output logic [SEG_W-1:0] seg_out,
    output logic             inv_n
);
    logic [CNT_W-1:0] ones;
    logic             heavy;

    always_comb begin
        ones    = seg_ones(seg_in);
        heavy   = (ones > CNT_W'(LOW_LIMIT));
        inv_n   = ~heavy;
        seg_out = heavy ? ~seg_in : seg_in;
    end
endmodule

// File: rtl/dbi_encoder.sv
module dbi_encoder
    import dbi_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_bus,
    output logic [N_SEG-1:0]  out_inv_n
);
    logic [DATA_W-1:0] bus_d;
    logic [N_SEG-1:0]  inv_d;

    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        dbi_seg_judge u_judge (
            .seg_in  (in_data[k*SEG_W +: SEG_W]),
            .seg_out (bus_d[k*SEG_W +: SEG_W]),
            .inv_n   (inv_d[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bus   <= '0;
            out_inv_n <= '1;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bus   <= bus_d;
                out_inv_n <= inv_d;
            end
        end
    end
endmodule

// File: rtl/dbi_decoder.sv
module dbi_decoder
    import dbi_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_bus,
    input  logic [N_SEG-1:0]  in_inv_n,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] data_d;

    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        assign data_d[k*SEG_W +: SEG_W] = in_inv_n[k] ? in_bus[k*SEG_W +: SEG_W]
                                                      : ~in_bus[k*SEG_W +: SEG_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= data_d;
            end
        end
    end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              txo_valid,
    output logic [DATA_W-1:0] txo_bus,
    output logic [N_SEG-1:0]  txo_inv_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_bus,
    input  logic [N_SEG-1:0]  rx_inv_n,
    output logic              rxo_valid,
    output logic [DATA_W-1:0] rxo_data
);
    dbi_encoder u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .out_valid (txo_valid),
        .out_bus   (txo_bus),
        .out_inv_n (txo_inv_n)
    );

    dbi_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_bus    (rx_bus),
        .in_inv_n  (rx_inv_n),
        .out_valid (rxo_valid),
        .out_data  (rxo_data)
    );
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk
    import dbi_codec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              txo_valid,
    input logic [DATA_W-1:0] txo_bus,
    input logic [N_SEG-1:0]  txo_inv_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_bus,
    input logic [N_SEG-1:0]  rx_inv_n,
    input logic              rxo_valid,
    input logic [DATA_W-1:0] rxo_data
);
    logic [DATA_W-1:0] tx_mask, rx_mask;

    always_comb begin
        for (int k = 0; k < N_SEG; k++) begin
            tx_mask[k*SEG_W +: SEG_W] = {SEG_W{~txo_inv_n[k]}};
            rx_mask[k*SEG_W +: SEG_W] = {SEG_W{~rx_inv_n[k]}};
        end
    end

    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        // R4: a presented segment never pulls more than half its lines low
        p_low_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
            txo_valid |-> ($countones(txo_bus[k*SEG_W +: SEG_W]) <= LOW_LIMIT));
        // R2: a complemented segment came from a heavy one, so it now has fewer than half
        p_inv_choice_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (txo_valid && !txo_inv_n[k]) |-> ($countones(txo_bus[k*SEG_W +: SEG_W]) < LOW_LIMIT));
    end

    // R7: valid follows its input by one cycle
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (txo_valid == $past(tx_valid)) && (rxo_valid == $past(rx_valid)));

    // R8: outputs hold while the valid input was low
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tx_valid)) |-> ($stable(txo_bus) && $stable(txo_inv_n)));
    p_hold_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rx_valid)) |-> $stable(rxo_data));

    // R10: flags applied to the sent word restore the accepted beat
    p_lossless_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_valid)) |-> ((txo_bus ^ tx_mask) == $past(tx_data)));

    // R5: decoder output is the received word corrected by its flags
    p_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rx_valid)) |-> (rxo_data == $past(rx_bus ^ rx_mask)));
endmodule

bind dbi_codec dbi_codec_chk u_chk (.*);

// File: tb/dbi_codec_bench.sv
`timescale 1ns/1ps
module dbi_codec_bench;
    import dbi_codec_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_valid = 1'b0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              txo_valid;
    logic [DATA_W-1:0] txo_bus;
    logic [N_SEG-1:0]  txo_inv_n;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_bus = '0;
    logic [N_SEG-1:0]  rx_inv_n = '1;
    logic              rxo_valid;
    logic [DATA_W-1:0] rxo_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic              pend_v = 1'b0;
    logic [DATA_W-1:0] pend_bus, pend_orig;
    logic [N_SEG-1:0]  pend_flags;

    always #2.5 clk = ~clk;

    dbi_codec u_dbi_codec (.*);

    function automatic int ones(input logic [SEG_W-1:0] v);
        int n = 0;
        for (int i = 0; i < SEG_W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [N_SEG-1:0] exp_flags(input logic [DATA_W-1:0] d);
        logic [N_SEG-1:0] f;
        for (int k = 0; k < N_SEG; k++) f[k] = (ones(d[k*SEG_W +: SEG_W]) > 8) ? 1'b0 : 1'b1;
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] apply(input logic [DATA_W-1:0] d, input logic [N_SEG-1:0] f);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < N_SEG; k++)
            r[k*SEG_W +: SEG_W] = f[k] ? d[k*SEG_W +: SEG_W] : ~d[k*SEG_W +: SEG_W];
        return r;
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drives one tx beat and, pipelined, decodes the previous encoded beat
    task automatic beat(input logic [DATA_W-1:0] d, input string req);
        tx_data  = d;
        tx_valid = 1'b1;
        rx_valid = pend_v;
        rx_bus   = pend_bus;
        rx_inv_n = pend_flags;
        @(negedge clk);
        check({req, " R7 txo_valid"}, DATA_W'(txo_valid), DATA_W'(1));
        check({req, " flags"}, DATA_W'(txo_inv_n), DATA_W'(exp_flags(d)));
        check({req, " bus"}, txo_bus, apply(d, exp_flags(d)));
        for (int k = 0; k < N_SEG; k++)
            if (ones(txo_bus[k*SEG_W +: SEG_W]) > 8) check("R4 low count", DATA_W'(ones(txo_bus[k*SEG_W +: SEG_W])), DATA_W'(8));
        if (pend_v) begin
            check("R10 round trip", rxo_data, pend_orig);
            check("R7 rxo_valid", DATA_W'(rxo_valid), DATA_W'(1));
        end
        pend_v = 1'b1;
        pend_bus = txo_bus;
        pend_flags = txo_inv_n;
        pend_orig = d;
    endtask

    task automatic flush();
        tx_valid = 1'b0;
        rx_valid = pend_v;
        rx_bus   = pend_bus;
        rx_inv_n = pend_flags;
        @(negedge clk);
        if (pend_v) check("R10 round trip tail", rxo_data, pend_orig);
        rx_valid = 1'b0;
        pend_v = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [DATA_W-1:0] hold_bus, hold_dec;
        logic [N_SEG-1:0]  hold_flags;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 txo_valid", DATA_W'(txo_valid), '0);
        check("R9 rxo_valid", DATA_W'(rxo_valid), '0);
        check("R9 txo_bus", txo_bus, '0);
        check("R9 txo_inv_n", DATA_W'(txo_inv_n), DATA_W'(4'hF));
        check("R9 rxo_data", rxo_data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: only segment 2 heavy
        beat(64'h0000_FFFF_0000_0000, "R1 seg2 only");
        check("R1 flag map", DATA_W'(txo_inv_n), DATA_W'(4'b1011));
        // R2 / R3 thresholds: 9 ones inverts, 8 ones passes
        beat(64'h01FF_00FF_01FF_00FF, "R2 R3 threshold");
        check("R3 exactly eight kept", DATA_W'(txo_inv_n), DATA_W'(4'b0101));
        beat(64'hFFFF_FFFF_FFFF_FFFF, "R2 all ones");
        check("R2 all ones to zero", txo_bus, '0);
        beat(64'h0, "R3 zero");
        // R6 back-to-back alternating patterns
        beat(64'hFFFF_0000_FFFF_0000, "R6 beat a");
        beat(64'h0000_FFFF_0000_FFFF, "R6 beat b");
        flush();

        // R8 hold while idle
        beat(64'hFFF0_1234_ABCD_8001, "R8 setup");
        flush();
        hold_bus = txo_bus;
        hold_flags = txo_inv_n;
        hold_dec = rxo_data;
        tx_data = 64'h5A5A_FFFF_0F0F_FF00;
        rx_bus = 64'hDEAD_BEEF_0000_1111;
        rx_inv_n = 4'b0000;
        repeat (3) @(negedge clk);
        check("R8 txo_bus hold", txo_bus, hold_bus);
        check("R8 txo_inv_n hold", DATA_W'(txo_inv_n), DATA_W'(hold_flags));
        check("R8 rxo_data hold", rxo_data, hold_dec);
        check("R7 txo_valid low", DATA_W'(txo_valid), '0);

        // R5 direct decode with arbitrary flags
        rx_bus = '0;
        rx_inv_n = 4'b0101;
        rx_valid = 1'b1;
        @(negedge clk);
        check("R5 decode flags 0101", rxo_data, 64'hFFFF_0000_FFFF_0000);
        rx_bus = 64'h1234_5678_9ABC_DEF0;
        rx_inv_n = 4'b1110;
        @(negedge clk);
        check("R5 decode flags 1110", rxo_data, 64'h1234_5678_9ABC_210F);
        rx_valid = 1'b0;
        @(negedge clk);

        // random beats, biased segment density
        for (int i = 0; i < 400; i++) begin
            logic [DATA_W-1:0] d;
            d = {$urandom, $urandom};
            if (i % 3 == 1) d = d | {$urandom, $urandom};
            if (i % 3 == 2) d = d & {$urandom, $urandom};
            beat(d, "R6 random");
            if (($urandom % 7) == 0) flush();
        end
        flush();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule